// File: doc/BRIEF.md
# Master configuration clock generator

This block drives the configuration clock pin of a device that acts as the clock master during configuration. It divides a fast free-running oscillator down to one of nineteen selectable rates. The rate is chosen by a 5-bit code that arrives with a load strobe. After reset, and after every new initialization, the output runs at the slowest rate (2.5 MHz). When a new code is loaded, the block moves to the new rate without producing a short pulse.

Configuration end is signalled by the done indication together with the wake-up-complete indication. From that point the block supplies exactly 120 more clock periods, so that downstream devices in a chain can finish waking up. It then parks the output low and tri-states the pin. The clock resumes only when the next initialization strobe arrives. When slave mode is selected, the pin is an input, so the output enable stays low.

Top module: `cfgclk_master`

## Requirements
- R1: While `master_sel` is low, `cclk_oe` and `cclk_o` are both low.
- R2: After reset, with no code loaded, each high phase and each low phase of `cclk_o` lasts round(OSC_KHZ / 5000) oscillator cycles. This is 52 cycles for the default OSC_KHZ of 260000.
- R3: Code values 0 to 18 select rates in ascending order: 2.5, 4.3, 5.4, 6.9, 8.1, 9.2, 10, 13, 15, 20, 26, 30, 34, 41, 45, 51, 55, 60 and 130 MHz. For a rate of f kHz, each phase lasts round(OSC_KHZ / (2f)) oscillator cycles, and never less than 1.
- R4: Code values 19 to 31 select the 2.5 MHz rate.
- R5: A loaded code takes effect only at the end of a low phase. The phase in progress when the load arrives completes at the old length, and every phase lasts either the old length or the new length.
- R6: Each rising edge of `cclk_o` launched while both `done_hi` and `wake_done` are high is counted. After the 120th counted edge, the clock completes that period and then stops, and `cclk_oe` falls at the point where the next rising edge would have occurred.
- R7: With only one of `done_hi` and `wake_done` high, the clock keeps running and `cclk_oe` stays high.
- R8: Once stopped, `cclk_o` is low and both outputs stay low until `init_pulse` arrives.
- R9: `init_pulse` restarts the clock from the low state at the 2.5 MHz rate, clears the edge count, discards any loaded code, and raises `cclk_oe` (in master mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Fast internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | High selects master mode (pin driven) |
| rate_code | input | 5 | Rate select code |
| rate_load | input | 1 | One-cycle strobe that captures `rate_code` |
| done_hi | input | 1 | Done indication is high |
| wake_done | input | 1 | Wake-up sequence has finished |
| init_pulse | input | 1 | One-cycle strobe marking a new initialization |
| cclk_o | output | 1 | Configuration clock output |
| cclk_oe | output | 1 | Output enable for the pin; low tri-states it |

## Verification
The bench loads a fast code in the middle of a long low phase and checks that this phase still runs its full old length. It also loads a slow code in the middle of a short high phase. A design that swapped the divisor at once would shorten the phase or stretch it to an odd length. The shutdown count is checked to the exact edge at two rates. An off-by-one in the counter, or a stop taken while the clock is high, would show up as 119 or 121 edges, or as a stop with the output high. The bench also drives done without wake-up, and unused codes. A design that stopped on either indication alone, or that fed an unused code through to the divider, would stop early or run at an undefined rate.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  localparam int NUM_RATES = 19;
  localparam int DEFAULT_KHZ = 2500;

  // Selectable output rates in kHz, ascending with the code value.
  function automatic int rate_khz(input int code);
    case (code)
      0:  return 2500;
      1:  return 4300;
      2:  return 5400;
      3:  return 6900;
      4:  return 8100;
      5:  return 9200;
      6:  return 10000;
      7:  return 13000;
      8:  return 15000;
      9:  return 20000;
      10: return 26000;
      11: return 30000;
      12: return 34000;
      13: return 41000;
      14: return 45000;
      15: return 51000;
      16: return 55000;
      17: return 60000;
      18: return 130000;
      default: return DEFAULT_KHZ;
    endcase
  endfunction

  // Oscillator cycles per output phase, rounded to nearest, at least one.
  function automatic int half_count(input int code, input int osc_khz);
    int f;
    int h;
    f = rate_khz(code);
    h = (osc_khz + f) / (2 * f);
    return (h < 1) ? 1 : h;
  endfunction

endpackage

// File: rtl/cfgclk_divsel.sv
module cfgclk_divsel #(
  parameter int OSC_KHZ = 260000,
  parameter int CODE_W  = 5,
  parameter int HALF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              swap_i,
  output logic [HALF_W-1:0] active_o
);
  import cfgclk_pkg::*;

  localparam logic [HALF_W-1:0] DEF_HALF = HALF_W'(half_count(0, OSC_KHZ));

  logic [HALF_W-1:0] pending_q;
  logic [HALF_W-1:0] active_q;
  logic [HALF_W-1:0] decoded;

  always_comb decoded = HALF_W'(half_count(int'(code_i), OSC_KHZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= DEF_HALF;
      active_q  <= DEF_HALF;
    end else if (init_i) begin
      pending_q <= DEF_HALF;
      active_q  <= DEF_HALF;
    end else begin
      if (swap_i) active_q <= pending_q;
      if (load_i) pending_q <= decoded;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/cfgclk_divider.sv
module cfgclk_divider #(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              run_i,
  input  logic              halt_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              clk_q,
  output logic              rise_ev,
  output logic              stop_ev
);
  logic [HALF_W-1:0] cnt_q;
  logic              phase_end;
  logic              fall_ev;

  always_comb begin
    phase_end = run_i && (cnt_q == half_i - HALF_W'(1));
    rise_ev   = phase_end && !clk_q && !halt_i;
    stop_ev   = phase_end && !clk_q && halt_i;
    fall_ev   = phase_end && clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (init_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (run_i) begin
      if (phase_end) begin
        cnt_q <= '0;
        if (rise_ev) clk_q <= 1'b1;
        else if (fall_ev) clk_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/cfgclk_stopctl.sv
module cfgclk_stopctl #(
  parameter int STOP_EDGES = 120,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             arm_i,
  input  logic             rise_ev,
  input  logic             stop_ev,
  output logic             run_o,
  output logic             halt_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STOP_EDGES);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (init_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      if (stop_ev) run_q <= 1'b0;
      if (rise_ev && arm_i && (cnt_q != LIMIT)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign run_o   = run_q;
  assign halt_o  = (cnt_q == LIMIT);
  assign count_o = cnt_q;
endmodule

// File: rtl/cfgclk_master.sv
module cfgclk_master #(
  parameter int OSC_KHZ    = 260000,
  parameter int CODE_W     = 5,
  parameter int STOP_EDGES = 120
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              rate_load,
  input  logic              done_hi,
  input  logic              wake_done,
  input  logic              init_pulse,
  output logic              cclk_o,
  output logic              cclk_oe
);
  localparam int MAX_HALF = cfgclk_pkg::half_count(0, OSC_KHZ);
  localparam int HALF_W   = $clog2(MAX_HALF + 1);
  localparam int CNT_W    = $clog2(STOP_EDGES + 1);

  logic [HALF_W-1:0] active_half;
  logic              clk_q;
  logic              rise_ev;
  logic              stop_ev;
  logic              running;
  logic              halt;
  logic              armed;
  logic [CNT_W-1:0]  edge_cnt;

  assign armed = done_hi && wake_done;

  cfgclk_divsel #(
    .OSC_KHZ(OSC_KHZ), .CODE_W(CODE_W), .HALF_W(HALF_W)
  ) u_divsel (
    .clk(clk_osc), .rst_n(rst_n), .init_i(init_pulse),
    .load_i(rate_load), .code_i(rate_code), .swap_i(rise_ev),
    .active_o(active_half)
  );

  cfgclk_divider #(.HALF_W(HALF_W)) u_div (
    .clk(clk_osc), .rst_n(rst_n), .init_i(init_pulse),
    .run_i(running), .halt_i(halt), .half_i(active_half),
    .clk_q(clk_q), .rise_ev(rise_ev), .stop_ev(stop_ev)
  );

  cfgclk_stopctl #(.STOP_EDGES(STOP_EDGES), .CNT_W(CNT_W)) u_stop (
    .clk(clk_osc), .rst_n(rst_n), .init_i(init_pulse),
    .arm_i(armed), .rise_ev(rise_ev), .stop_ev(stop_ev),
    .run_o(running), .halt_o(halt), .count_o(edge_cnt)
  );

  assign cclk_o  = master_sel && clk_q;
  assign cclk_oe = master_sel && running;
endmodule

// File: rtl/cfgclk_master_chk.sv
module cfgclk_master_chk #(
  parameter int HALF_W     = 6,
  parameter int CNT_W      = 7,
  parameter int STOP_EDGES = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_sel,
  input logic              init_pulse,
  input logic              cclk_o,
  input logic              cclk_oe,
  input logic              rise_ev,
  input logic              running,
  input logic [HALF_W-1:0] active_half,
  input logic [CNT_W-1:0]  edge_cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STOP_EDGES);

  a_r1_slave_off: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !cclk_oe);

  a_r5_swap_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && !init_pulse) |=> $stable(active_half));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= LIMIT);

  a_r6_stop_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cclk_oe) && master_sel && $past(master_sel)) |-> ($past(edge_cnt) == LIMIT));

  a_r8_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_oe |-> !cclk_o);

  a_r8_stay_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !init_pulse) |=> !running);

  a_r9_init_runs: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> running);
endmodule

bind cfgclk_master cfgclk_master_chk #(
  .HALF_W(HALF_W), .CNT_W(CNT_W), .STOP_EDGES(STOP_EDGES)
) u_chk (
  .clk(clk_osc), .rst_n(rst_n), .master_sel(master_sel),
  .init_pulse(init_pulse), .cclk_o(cclk_o), .cclk_oe(cclk_oe),
  .rise_ev(rise_ev), .running(running), .active_half(active_half),
  .edge_cnt(edge_cnt)
);

// File: tb/tb_cfgclk_master.sv
module tb_cfgclk_master;
  localparam int OSC_KHZ = 260000;
  localparam int NV = 12;
  localparam int VCODE [NV] = '{0, 1, 2, 5, 7, 9, 12, 15, 17, 18, 19, 31};
  localparam int VKHZ  [NV] = '{2500, 4300, 5400, 9200, 13000, 20000,
                                34000, 51000, 60000, 130000, 2500, 2500};

  logic       clk_osc = 0;
  logic       rst_n = 0;
  logic       master_sel = 1;
  logic [4:0] rate_code = '0;
  logic       rate_load = 0;
  logic       done_hi = 0;
  logic       wake_done = 0;
  logic       init_pulse = 0;
  logic       cclk_o;
  logic       cclk_oe;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk_osc = ~clk_osc;

  cfgclk_master dut (
    .clk_osc(clk_osc), .rst_n(rst_n), .master_sel(master_sel),
    .rate_code(rate_code), .rate_load(rate_load), .done_hi(done_hi),
    .wake_done(wake_done), .init_pulse(init_pulse),
    .cclk_o(cclk_o), .cclk_oe(cclk_oe)
  );

  function automatic int exp_half(input int khz);
    int h;
    h = $rtoi(real'(OSC_KHZ) / (2.0 * real'(khz)) + 0.5);
    return (h < 1) ? 1 : h;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_init();
    @(negedge clk_osc) init_pulse = 1;
    @(negedge clk_osc) init_pulse = 0;
  endtask

  task automatic load_code(input int c);
    @(negedge clk_osc);
    rate_code = 5'(c);
    rate_load = 1;
    @(negedge clk_osc) rate_load = 0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = cclk_o;
    forever begin
      @(negedge clk_osc);
      if (!prev && cclk_o) break;
      prev = cclk_o;
    end
  endtask

  task automatic wait_fall();
    logic prev;
    prev = cclk_o;
    forever begin
      @(negedge clk_osc);
      if (prev && !cclk_o) break;
      prev = cclk_o;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 0;
    while (cclk_o) begin hi++; @(negedge clk_osc); end
    lo = 0;
    while (!cclk_o && cclk_oe) begin lo++; @(negedge clk_osc); end
  endtask

  task automatic count_to_stop(output int rises);
    logic prev;
    int n;
    prev = cclk_o;
    rises = 0;
    n = 0;
    while (cclk_oe && n < 40000) begin
      @(negedge clk_osc);
      n++;
      if (!prev && cclk_o) rises++;
      prev = cclk_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_osc);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int hi;
    int lo;
    int rises;
    int highs;
    repeat (4) @(negedge clk_osc);
    rst_n = 1;
    @(negedge clk_osc);
    check("R2", "reset oe", int'(cclk_oe), 1);
    check("R2", "reset clk low", int'(cclk_o), 0);
    measure(hi, lo);
    check("R2", "default high", hi, exp_half(2500));
    check("R2", "default low", lo, exp_half(2500));

    // R1: slave mode keeps the pin released and the output low.
    @(negedge clk_osc) master_sel = 0;
    highs = 0;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk_osc);
      if (cclk_o || cclk_oe) highs++;
    end
    check("R1", "slave oe/out activity", highs, 0);
    master_sel = 1;
    @(negedge clk_osc);
    check("R1", "master oe back", int'(cclk_oe), 1);

    // Rate table walk (R3 for codes 0..18, R4 for unused codes).
    for (int i = 0; i < NV; i++) begin
      pulse_init();
      load_code(VCODE[i]);
      wait_rise();
      measure(hi, lo);
      check(VCODE[i] > 18 ? "R4" : "R3", $sformatf("code %0d high", VCODE[i]), hi, exp_half(VKHZ[i]));
      check(VCODE[i] > 18 ? "R4" : "R3", $sformatf("code %0d low", VCODE[i]), lo, exp_half(VKHZ[i]));
    end

    // R5: slow to fast, load in the middle of a long low phase.
    pulse_init();
    wait_fall();
    lo = 0;
    while (!cclk_o) begin
      lo++;
      if (lo == 10) begin rate_code = 5'd18; rate_load = 1; end
      else rate_load = 0;
      @(negedge clk_osc);
    end
    rate_load = 0;
    check("R5", "low phase at load keeps old length", lo, exp_half(2500));
    hi = 0;
    while (cclk_o) begin hi++; @(negedge clk_osc); end
    lo = 0;
    while (!cclk_o) begin lo++; @(negedge clk_osc); end
    check("R5", "first new high", hi, exp_half(130000));
    check("R5", "first new low", lo, exp_half(130000));

    // R5: fast to slow, load in the middle of a high phase.
    pulse_init();
    load_code(7);
    wait_rise();
    wait_rise();
    hi = 0;
    while (cclk_o) begin
      hi++;
      if (hi == 3) begin rate_code = 5'd0; rate_load = 1; end
      else rate_load = 0;
      @(negedge clk_osc);
    end
    rate_load = 0;
    lo = 0;
    while (!cclk_o) begin lo++; @(negedge clk_osc); end
    check("R5", "high at load keeps old length", hi, exp_half(13000));
    check("R5", "low after load keeps old length", lo, exp_half(13000));
    hi = 0;
    while (cclk_o) begin hi++; @(negedge clk_osc); end
    check("R5", "next high at new length", hi, exp_half(2500));

    // R7: done without wake-up does not stop the clock.
    pulse_init();
    load_code(18);
    wait_rise();
    @(negedge clk_osc) done_hi = 1;
    repeat (600) @(negedge clk_osc);
    check("R7", "done alone oe", int'(cclk_oe), 1);
    done_hi = 0;
    wake_done = 1;
    repeat (600) @(negedge clk_osc);
    check("R7", "wake alone oe", int'(cclk_oe), 1);
    wake_done = 0;

    // R6/R8: shutdown after 120 counted edges, fast rate.
    pulse_init();
    load_code(18);
    wait_rise();
    @(negedge clk_osc);
    done_hi = 1;
    wake_done = 1;
    count_to_stop(rises);
    check("R6", "edges before stop fast", rises, 120);
    check("R8", "stopped output low", int'(cclk_o), 0);
    highs = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk_osc);
      if (cclk_o || cclk_oe) highs++;
    end
    check("R8", "stays stopped", highs, 0);
    done_hi = 0;
    wake_done = 0;

    // R9: next initialization restarts at default rate.
    pulse_init();
    check("R9", "oe after init", int'(cclk_oe), 1);
    measure(hi, lo);
    check("R9", "restart high", hi, exp_half(2500));
    check("R9", "restart low", lo, exp_half(2500));

    // R6: shutdown at a medium rate, armed during a high phase.
    pulse_init();
    load_code(7);
    wait_rise();
    wait_rise();
    @(negedge clk_osc);
    done_hi = 1;
    wake_done = 1;
    count_to_stop(rises);
    check("R6", "edges before stop medium", rises, 120);
    check("R8", "stopped output low medium", int'(cclk_o), 0);
    done_hi = 0;
    wake_done = 0;
    pulse_init();
    check("R9", "oe after second init", int'(cclk_oe), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule